// File: doc/BRIEF.md
# Flash Completion Interrupt Flag Unit

This block keeps two sticky completion flags for a flash memory controller, one for the end of an erase job and one for the end of a programming job, and turns them into a single level interrupt request for the system interrupt controller. The flash sequencer reports each completion with a one-cycle pulse. The erase pulse is issued once, after every sector of the requested erase has finished, and not once per sector.

Software reaches the block over a simple register bus with a write strobe, a read strobe, a byte address and a data word. There are four registers:

- A read-only status register that shows the flags.
- A read/write enable register that masks each flag.
- A write-one-to-clear register.
- A write-one-to-set register.

The set register lets software raise a completion flag by hand, which stands in for a real flash operation during development. Read data is registered and appears in the cycle after the read strobe.

Top module: `flash_irq_unit`

## Requirements
- R1: After reset, both flags, both enable bits and the interrupt request are 0.
- R2: A one-cycle pulse on `erase_done` sets flag bit 0 (end of erase), and a pulse on `prog_done` sets flag bit 1 (end of program). The flags are visible at status offset 0x0 after the clock edge that samples the pulse.
- R3: A set flag stays set, whatever further events arrive, until software clears it.
- R4: Writing offset 0xC sets each flag whose data bit is 1. Data bits that are 0 leave their flag unchanged.
- R5: Writing offset 0x8 clears each flag whose data bit is 1. Data bits that are 0 leave their flag unchanged.
- R6: When a set (a hardware pulse or a write to 0xC) and a clear write hit the same flag in the same cycle, the flag ends up set.
- R7: `irq` is 1 in the cycle after any flag and its enable bit are both 1. A flag set by software raises it exactly as a hardware pulse does.
- R8: `irq` returns to 0 in the cycle after the last enabled flag is cleared, or after its enable bit is cleared.
- R9: The enable register at offset 0x4 is read/write. Bit 0 masks the erase flag and bit 1 masks the program flag.
- R10: The status register is read-only: a write to offset 0x0 changes no flag. Read data from offsets 0x0 and 0x4 has every bit above bit 1 at 0, and a write that carries ones in those upper bits stores nothing there.
- R11: `bus_rdata` updates at the clock edge that samples `bus_rd` and then holds its value. Offsets 0x8, 0xC and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| erase_done | input | 1 | One-cycle pulse: requested erase fully finished |
| prog_done | input | 1 | One-cycle pulse: programming operation finished |
| irq | output | 1 | Registered level interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit address and a 32-bit data word. With a 32-bit word there are thirty reserved bits above the two flag positions. Writing all ones to every register therefore checks that nothing lands in those bits and that they read back as 0. The 8-bit address leaves room for an unmapped offset, which the bench reads to confirm it returns zero.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int NUM_FLAGS = 2;
  localparam int FLG_ERASE = 0;
  localparam int FLG_PROG  = 1;
  localparam logic [7:0] OFF_STAT = 8'h00;
  localparam logic [7:0] OFF_EN   = 8'h04;
  localparam logic [7:0] OFF_CLR  = 8'h08;
  localparam logic [7:0] OFF_SET  = 8'h0C;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/flash_irq_regif.sv
module flash_irq_regif
  import flash_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  flag_vec_t         flags,
  output flag_vec_t         set_mask,
  output flag_vec_t         clr_mask,
  output flag_vec_t         enables,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFF_SET);

  flag_vec_t         en_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  flag_vec_t         wr_bits;

  assign wr_bits  = bus_wdata[NUM_FLAGS-1:0];
  assign set_mask = (bus_wr && bus_addr == A_SET) ? wr_bits : '0;
  assign clr_mask = (bus_wr && bus_addr == A_CLR) ? wr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (bus_wr && bus_addr == A_EN) en_q <= wr_bits;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_STAT)    rd_mux = DATA_W'(flags);
    else if (bus_addr == A_EN) rd_mux = DATA_W'(en_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign enables   = en_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/flash_irq_flags.sv
module flash_irq_flags
  import flash_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_vec_t hw_evt,
  input  flag_vec_t set_mask,
  input  flag_vec_t clr_mask,
  output flag_vec_t flags
);
  flag_vec_t flag_q;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else if (hw_evt[i] || set_mask[i]) flag_q[i] <= 1'b1;
      else if (clr_mask[i]) flag_q[i] <= 1'b0;
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/flash_irq_req.sv
module flash_irq_req
  import flash_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_vec_t flags,
  input  flag_vec_t enables,
  output logic      irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else irq_q <= |(flags & enables);
  end

  assign irq = irq_q;
endmodule

// File: rtl/flash_irq_unit.sv
module flash_irq_unit
  import flash_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              erase_done,
  input  logic              prog_done,
  output logic              irq
);
  flag_vec_t hw_evt;
  flag_vec_t set_mask;
  flag_vec_t clr_mask;
  flag_vec_t enables;
  flag_vec_t flags;

  always_comb begin
    hw_evt            = '0;
    hw_evt[FLG_ERASE] = erase_done;
    hw_evt[FLG_PROG]  = prog_done;
  end

  flash_irq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .flags    (flags),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .enables  (enables),
    .bus_rdata(bus_rdata)
  );

  flash_irq_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .hw_evt  (hw_evt),
    .set_mask(set_mask),
    .clr_mask(clr_mask),
    .flags   (flags)
  );

  flash_irq_req u_req (
    .clk    (clk),
    .rst    (rst),
    .flags  (flags),
    .enables(enables),
    .irq    (irq)
  );
endmodule

// File: rtl/flash_irq_checker.sv
module flash_irq_checker
  import flash_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              erase_done,
  input logic              prog_done,
  input flag_vec_t         flags,
  input flag_vec_t         enables,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFF_SET);

  logic clr_erase;
  logic set_erase;
  logic clr_prog;

  assign clr_erase = bus_wr && bus_addr == A_CLR && bus_wdata[FLG_ERASE];
  assign set_erase = bus_wr && bus_addr == A_SET && bus_wdata[FLG_ERASE];
  assign clr_prog  = bus_wr && bus_addr == A_CLR && bus_wdata[FLG_PROG];

  // R2
  erase_evt_chk: assert property (@(posedge clk) disable iff (rst)
    erase_done |=> flags[FLG_ERASE]);

  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flags[FLG_ERASE] && !clr_erase) |=> flags[FLG_ERASE]);

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_erase && !set_erase && !erase_done) |=> !flags[FLG_ERASE]);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_done && clr_prog) |=> flags[FLG_PROG]);

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(flags & enables)) |=> irq);

  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ((flags & enables) == '0) |=> !irq);

  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_STAT) |=> (bus_rdata[DATA_W-1:NUM_FLAGS] == '0));
endmodule

bind flash_irq_unit flash_irq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .erase_done(erase_done),
  .prog_done (prog_done),
  .flags     (flags),
  .enables   (enables),
  .irq       (irq)
);

// File: tb/flash_irq_unit_tb.sv
module flash_irq_unit_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              erase_done = 1'b0;
  logic              prog_done = 1'b0;
  logic              irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  flash_irq_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .erase_done(erase_done), .prog_done(prog_done), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic er, input logic pr);
    erase_done = er; prog_done = pr;
    @(negedge clk);
    erase_done = 1'b0; prog_done = 1'b0;
  endtask

  task automatic clear_all();
    wr(8'h08, 32'h3);
    wr(8'h04, 32'h0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] d;
    check("R1", "irq after reset", DATA_W'(irq), 0);
    rd(8'h00, d); check("R1", "status after reset", d, 0);
    rd(8'h04, d); check("R1", "enable after reset", d, 0);
  endtask

  task automatic t_hw_events();
    logic [DATA_W-1:0] d;
    pulse(1'b1, 1'b0);
    rd(8'h00, d); check("R2", "erase pulse sets bit0", d, 32'h1);
    pulse(1'b0, 1'b1);
    rd(8'h00, d); check("R2", "program pulse sets bit1", d, 32'h3);
    repeat (3) @(negedge clk);
    pulse(1'b1, 1'b1);
    rd(8'h00, d); check("R3", "flags stay set", d, 32'h3);
    check("R7", "irq low with enables off", DATA_W'(irq), 0);
    clear_all();
  endtask

  task automatic t_set_clear();
    logic [DATA_W-1:0] d;
    wr(8'h0C, 32'h2);
    rd(8'h00, d); check("R4", "set write bit1 only", d, 32'h2);
    wr(8'h0C, 32'h0);
    rd(8'h00, d); check("R4", "set write of zeros", d, 32'h2);
    wr(8'h0C, 32'h1);
    wr(8'h08, 32'h0);
    rd(8'h00, d); check("R5", "clear write of zeros", d, 32'h3);
    wr(8'h08, 32'h1);
    rd(8'h00, d); check("R5", "clear bit0 only", d, 32'h2);
    clear_all();
    rd(8'h00, d); check("R5", "clear both", d, 32'h0);
  endtask

  task automatic t_priority();
    logic [DATA_W-1:0] d;
    erase_done = 1'b1;
    wr(8'h08, 32'h1);
    erase_done = 1'b0;
    rd(8'h00, d); check("R6", "hw set beats clear", d, 32'h1);
    clear_all();
    prog_done = 1'b1;
    wr(8'h08, 32'h2);
    prog_done = 1'b0;
    rd(8'h00, d); check("R6", "program set beats clear", d, 32'h2);
    clear_all();
  endtask

  task automatic t_irq();
    logic [DATA_W-1:0] d;
    wr(8'h04, 32'h2);
    rd(8'h04, d); check("R9", "enable readback", d, 32'h2);
    pulse(1'b1, 1'b0);
    @(negedge clk);
    check("R7", "erase flag masked", DATA_W'(irq), 0);
    wr(8'h0C, 32'h2);
    check("R7", "irq not yet high at flag edge", DATA_W'(irq), 0);
    @(negedge clk);
    check("R7", "software set raises irq", DATA_W'(irq), 1);
    wr(8'h08, 32'h2);
    check("R8", "irq still high one cycle", DATA_W'(irq), 1);
    @(negedge clk);
    check("R8", "irq drops after clear", DATA_W'(irq), 0);
    wr(8'h04, 32'h1);
    @(negedge clk);
    check("R7", "enable raises irq on pending flag", DATA_W'(irq), 1);
    wr(8'h04, 32'h0);
    @(negedge clk);
    check("R8", "irq drops after disable", DATA_W'(irq), 0);
    clear_all();
  endtask

  task automatic t_reserved();
    logic [DATA_W-1:0] d;
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R10", "status is read-only", d, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R10", "enable upper bits zero", d, 32'h3);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R10", "status upper bits zero", d, 32'h3);
    rd(8'h08, d); check("R11", "clear reg reads 0", d, 32'h0);
    rd(8'h0C, d); check("R11", "set reg reads 0", d, 32'h0);
    rd(8'h40, d); check("R11", "unmapped reads 0", d, 32'h0);
    rd(8'h04, d);
    repeat (2) @(negedge clk);
    check("R11", "read data holds", bus_rdata, 32'h3);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_hw_events();
    t_set_clear();
    t_priority();
    t_irq();
    t_reserved();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule